// File: doc/BRIEF.md
# Reference and Feedback Divider Pair

This block supplies the two divided clocks that a frequency-synthesis loop compares. A reference counter, clocked by the input reference, divides by a 7-bit word plus two. A feedback counter, clocked at oscillator rate, divides by twice the sum of a 9-bit word and eight. Each counter emits a pulse one cycle of its own clock wide once per divided period. A phase comparator downstream takes these two pulse trains.

Each counter is a small state machine with two states: `ST_HALT` (stopped, output low) and `ST_RUN` (counting down). The transitions are named `T_WAKE` (HALT to RUN when the power-enable input is high), `T_SLEEP` (RUN to HALT when it is low), `T_WRAP` (RUN to RUN at terminal count, which pulses and reloads) and `T_TICK` (RUN to RUN otherwise, a decrement). A word is sampled only on `T_WAKE` or `T_WRAP`, so a period already under way always completes at its loaded length. A legality check looks at the words the counters hold. When the restricted variant is strapped, it raises a flag for words that variant does not allow. The active-low power-down input stops both counters and forces every output low.

Top module: `pll_div_pair`

## Requirements
- R1: In steady state the reference pulse repeats every `ref_word + 2` rising edges of `ref_clk` (word 0 gives 2, word 127 gives 129).
- R2: In steady state the feedback pulse repeats every `2 * (vco_word + 8)` rising edges of `vco_clk` (word 0 gives 16, word 511 gives 1038).
- R3: Each pulse output is high for exactly one cycle of its own clock per divided period.
- R4: A word is sampled on the rising edge at which the pulse rises. A change made after that edge leaves the period in progress at its old length and sets the length of the following period.
- R5: While `pd_n` is 0, `ref_pulse`, `fb_pulse` and `cfg_bad` are all 0 and neither counter advances.
- R6: After `pd_n` returns to 1, the first pulse rises on the R-th rising edge after the edge that first samples `pd_n` high, where R is the ratio of the word sampled on that edge.
- R7: With `variant_orig` = 1, a held reference word of 0 sets `cfg_bad` to 1, and a held reference word of 1 does not.
- R8: With `variant_orig` = 1, held feedback words 0, 1, 2 and 3 set `cfg_bad` to 1, and word 4 does not.
- R9: With `variant_orig` = 0, no word value sets `cfg_bad`.
- R10: While `rst_n` is 0, both pulses are 0 and both held words are all ones, so `cfg_bad` reads 0 whatever the word inputs are.
- R11: `cfg_bad` follows the held words, not the inputs. It changes only when a counter reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference-rate clock |
| vco_clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_n | input | 1 | Power enable; 0 halts both counters and forces outputs low |
| variant_orig | input | 1 | 1 selects the restricted word set |
| ref_word | input | 7 | Reference divide word |
| vco_word | input | 9 | Feedback divide word |
| ref_pulse | output | 1 | Divided reference pulse |
| fb_pulse | output | 1 | Divided feedback pulse |
| cfg_bad | output | 1 | Held word is illegal for the selected variant |

## Verification
A pulse set at rising edge k becomes visible between edges k and k+1. The bench therefore samples on falling edges, and a period of R edges shows up as R falling edges between pulses. After a wake, the first pulse appears on the R+1-th falling edge counted from the one at which `pd_n` was raised. A word change takes effect one full period after the pulse that follows it, so each ratio check first lets one period go by and then measures the next. The flag moves only at reloads, so it is read after two pulses in each domain.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
    localparam int REF_WORD_W = 7;
    localparam int FB_WORD_W  = 9;
    localparam int REF_OFFSET = 2;
    localparam int REF_SCALE  = 1;
    localparam int FB_OFFSET  = 8;
    localparam int FB_SCALE   = 2;
    localparam int FB_MIN_OK  = 4;
    localparam int REF_MIN_OK = 1;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/div_counter.sv
module div_counter
    import pll_div_pkg::*;
#(
    parameter int WORD_W = 7,
    parameter int OFFSET = 2,
    parameter int SCALE  = 1,
    parameter int CNT_W  = $clog2(((1 << WORD_W) - 1 + OFFSET) * SCALE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic [WORD_W-1:0] word_in,
    output logic              pulse,
    output logic [WORD_W-1:0] word_held
);
    localparam logic [WORD_W-1:0] WORD_DEFAULT = '1;

    div_state_e        state_q, state_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] word_q;
    logic              pulse_q;
    logic              at_terminal;

    function automatic logic [CNT_W-1:0] load_of(input logic [WORD_W-1:0] w);
        int ratio;
        ratio = (int'(w) + OFFSET) * SCALE;
        return CNT_W'(ratio - 1);
    endfunction

    assign at_terminal = (cnt_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_nxt;
    end

    // Next state: T_WAKE, T_SLEEP, T_WRAP, T_TICK
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_HALT: if (run_req)  state_nxt = ST_RUN;
            ST_RUN:  if (!run_req) state_nxt = ST_HALT;
            default: state_nxt = ST_HALT;
        endcase
    end

    // Counter, held word and pulse register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= load_of(WORD_DEFAULT);
            word_q  <= WORD_DEFAULT;
            pulse_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HALT: begin
                    pulse_q <= 1'b0;
                    if (run_req) begin
                        cnt_q  <= load_of(word_in);
                        word_q <= word_in;
                    end
                end
                ST_RUN: begin
                    if (!run_req) begin
                        pulse_q <= 1'b0;
                    end else if (at_terminal) begin
                        pulse_q <= 1'b1;
                        cnt_q   <= load_of(word_in);
                        word_q  <= word_in;
                    end else begin
                        pulse_q <= 1'b0;
                        cnt_q   <= cnt_q - 1'b1;
                    end
                end
                default: pulse_q <= 1'b0;
            endcase
        end
    end

    assign pulse     = pulse_q & run_req;
    assign word_held = word_q;
endmodule

// File: rtl/cfg_legality.sv
module cfg_legality
    import pll_div_pkg::*;
#(
    parameter int REF_W   = REF_WORD_W,
    parameter int FB_W    = FB_WORD_W,
    parameter int REF_MIN = REF_MIN_OK,
    parameter int FB_MIN  = FB_MIN_OK
) (
    input  logic             variant_orig,
    input  logic [REF_W-1:0] ref_held,
    input  logic [FB_W-1:0]  fb_held,
    output logic             ref_bad,
    output logic             fb_bad
);
    always_comb begin
        ref_bad = variant_orig && (int'(ref_held) < REF_MIN);
        fb_bad  = variant_orig && (int'(fb_held)  < FB_MIN);
    end
endmodule

// File: rtl/pll_div_pair.sv
module pll_div_pair
    import pll_div_pkg::*;
#(
    parameter int RW = REF_WORD_W,
    parameter int FW = FB_WORD_W
) (
    input  logic          ref_clk,
    input  logic          vco_clk,
    input  logic          rst_n,
    input  logic          pd_n,
    input  logic          variant_orig,
    input  logic [RW-1:0] ref_word,
    input  logic [FW-1:0] vco_word,
    output logic          ref_pulse,
    output logic          fb_pulse,
    output logic          cfg_bad
);
    logic [RW-1:0] ref_held;
    logic [FW-1:0] fb_held;
    logic          ref_bad, fb_bad;

    div_counter #(.WORD_W(RW), .OFFSET(REF_OFFSET), .SCALE(REF_SCALE)) u_ref (
        .clk(ref_clk), .rst_n(rst_n), .run_req(pd_n),
        .word_in(ref_word), .pulse(ref_pulse), .word_held(ref_held)
    );

    div_counter #(.WORD_W(FW), .OFFSET(FB_OFFSET), .SCALE(FB_SCALE)) u_fb (
        .clk(vco_clk), .rst_n(rst_n), .run_req(pd_n),
        .word_in(vco_word), .pulse(fb_pulse), .word_held(fb_held)
    );

    cfg_legality #(.REF_W(RW), .FB_W(FW)) u_legal (
        .variant_orig(variant_orig), .ref_held(ref_held), .fb_held(fb_held),
        .ref_bad(ref_bad), .fb_bad(fb_bad)
    );

    assign cfg_bad = pd_n & (ref_bad | fb_bad);
endmodule

// File: rtl/pll_div_pair_chk.sv
module pll_div_pair_chk (
    input logic       ref_clk,
    input logic       vco_clk,
    input logic       rst_n,
    input logic       pd_n,
    input logic [6:0] ref_word,
    input logic [8:0] vco_word,
    input logic       ref_pulse,
    input logic       fb_pulse
);
    logic [6:0]  rw_prev;
    logic [8:0]  fw_prev;
    logic [11:0] r_gap, r_exp, f_gap, f_exp;
    logic        r_arm, f_arm;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_prev <= '0; r_gap <= '0; r_exp <= '0; r_arm <= 1'b0;
        end else begin
            rw_prev <= ref_word;
            if (!pd_n) r_arm <= 1'b0;
            else if (ref_pulse) begin
                r_arm <= 1'b1;
                r_gap <= 12'd1;
                r_exp <= 12'(rw_prev) + 12'd2;
            end else r_gap <= r_gap + 12'd1;
        end
    end

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            fw_prev <= '0; f_gap <= '0; f_exp <= '0; f_arm <= 1'b0;
        end else begin
            fw_prev <= vco_word;
            if (!pd_n) f_arm <= 1'b0;
            else if (fb_pulse) begin
                f_arm <= 1'b1;
                f_gap <= 12'd1;
                f_exp <= (12'(fw_prev) + 12'd8) << 1;
            end else f_gap <= f_gap + 12'd1;
        end
    end

    AST_REF_PERIOD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (r_arm && ref_pulse && pd_n) |-> (r_gap == r_exp)); // R1
    AST_FB_PERIOD: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (f_arm && fb_pulse && pd_n) |-> (f_gap == f_exp)); // R2
    AST_REF_ONE_CYCLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse); // R3
    AST_FB_ONE_CYCLE: assert property (@(posedge vco_clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse); // R3
    AST_REF_WAKE_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(pd_n) |=> !ref_pulse); // R6
    AST_FB_WAKE_QUIET: assert property (@(posedge vco_clk) disable iff (!rst_n)
        $rose(pd_n) |=> !fb_pulse); // R6
endmodule

bind pll_div_pair pll_div_pair_chk u_chk (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .pd_n(pd_n),
    .ref_word(ref_word), .vco_word(vco_word),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse)
);

// File: tb/tb_pll_div_pair.sv
module tb_pll_div_pair;
    logic       ref_clk = 1'b0;
    logic       vco_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_n = 1'b1;
    logic       variant_orig = 1'b1;
    logic [6:0] ref_word = '0;
    logic [8:0] vco_word = '0;
    logic       ref_pulse, fb_pulse, cfg_bad;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pll_div_pair dut (
        .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .pd_n(pd_n),
        .variant_orig(variant_orig), .ref_word(ref_word), .vco_word(vco_word),
        .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .cfg_bad(cfg_bad)
    );

    always #2 ref_clk = ~ref_clk;
    initial begin
        #1;
        forever #2 vco_clk = ~vco_clk;
    end

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit fb);
        if (fb) @(negedge vco_clk);
        else    @(negedge ref_clk);
    endtask

    task automatic next_pulse(input bit fb, output int n);
        n = 0;
        do begin
            step(fb);
            n++;
        end while (!(fb ? fb_pulse : ref_pulse) && n < 3000);
    endtask

    task automatic t_reset;
        int n;
        ref_word = '0; vco_word = '0; variant_orig = 1'b1; pd_n = 1'b1;
        repeat (3) step(0);
        check(ref_pulse, 0, "R10 ref_pulse in reset");
        check(fb_pulse, 0, "R10 fb_pulse in reset");
        check(cfg_bad, 0, "R10 flag in reset with zero words");
        rst_n = 1'b1;
        next_pulse(0, n);
        next_pulse(1, n);
    endtask

    task automatic t_ref_ratio(input int w);
        int n;
        ref_word = 7'(w);
        next_pulse(0, n);
        next_pulse(0, n);
        check(n, w + 2, $sformatf("R1 ref period word %0d", w));
        step(0);
        check(ref_pulse, 0, "R3 ref pulse width");
    endtask

    task automatic t_fb_ratio(input int w);
        int n;
        vco_word = 9'(w);
        next_pulse(1, n);
        next_pulse(1, n);
        check(n, 2 * (w + 8), $sformatf("R2 fb period word %0d", w));
        step(1);
        check(fb_pulse, 0, "R3 fb pulse width");
    endtask

    task automatic t_midchange;
        int n;
        ref_word = 7'd10;
        next_pulse(0, n);
        next_pulse(0, n);
        ref_word = 7'd3;
        next_pulse(0, n);
        check(n, 12, "R4 period in progress keeps old length");
        next_pulse(0, n);
        check(n, 5, "R4 following period uses new word");
    endtask

    task automatic t_flag(input bit var_o, input int rw, input int vw, input int exp, input string req);
        int n;
        variant_orig = var_o; ref_word = 7'(rw); vco_word = 9'(vw);
        next_pulse(0, n); next_pulse(0, n);
        next_pulse(1, n); next_pulse(1, n);
        step(0);
        check(cfg_bad, exp, req);
    endtask

    task automatic t_flag_lag;
        int n;
        variant_orig = 1'b1; vco_word = 9'd40; ref_word = 7'd100;
        next_pulse(0, n); next_pulse(0, n);
        next_pulse(1, n); next_pulse(1, n);
        next_pulse(0, n);
        ref_word = 7'd0;
        repeat (5) step(0);
        check(cfg_bad, 0, "R11 flag holds until reload");
        next_pulse(0, n);
        step(0);
        check(cfg_bad, 1, "R11 flag follows reloaded word");
    endtask

    task automatic t_powerdown;
        int n;
        int seen;
        seen = 0;
        step(0);
        check(cfg_bad, 1, "R7 precondition flag set");
        ref_word = 7'd20; vco_word = 9'd5;
        pd_n = 1'b0;
        repeat (100) begin
            step(0);
            seen += ref_pulse + fb_pulse + cfg_bad;
        end
        check(seen, 0, "R5 outputs low in power-down");
        pd_n = 1'b1;
        next_pulse(0, n);
        check(n, 23, "R6 first ref pulse after wake");
        step(1);
        pd_n = 1'b0;
        repeat (40) step(1);
        pd_n = 1'b1;
        next_pulse(1, n);
        check(n, 27, "R6 first fb pulse after wake");
    endtask

    initial begin
        #600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_ref_ratio(0);
        t_ref_ratio(1);
        t_ref_ratio(127);
        t_ref_ratio(45);
        t_fb_ratio(0);
        t_fb_ratio(1);
        t_fb_ratio(511);
        t_fb_ratio(100);
        t_midchange;
        t_flag(1'b1, 1, 4, 0, "R8 word 4 legal and R7 word 1 legal");
        t_flag(1'b1, 5, 3, 1, "R8 fb word 3 illegal");
        t_flag(1'b1, 5, 0, 1, "R8 fb word 0 illegal");
        t_flag(1'b0, 0, 0, 0, "R9 extended set accepts zero words");
        t_flag_lag;
        t_flag(1'b1, 0, 30, 1, "R7 ref word 0 illegal");
        t_powerdown;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule